// File: doc/BRIEF.md
# Programmable Interval Counter Channel

The block is one 16-bit down-counting channel of a programmable interval timer. A host on a byte-wide bus, which runs on the system clock, programs it. One bus address takes a write-only control word. The other address reads and writes the count register. A control word sets the byte access order, one of six operating modes and binary or BCD arithmetic. It can also freeze the current count for a later read.

The counting clock and the gate come in on pins `cnt_clk_i` and `gate_i`. Both are brought into the system clock domain. Only a sampled rising edge of the counting clock advances the channel, and that edge is called a tick below. The gate either enables counting or acts as a trigger, depending on the mode. `out_o` produces the waveform of the selected mode. It can be a level change at terminal count, a one-shot pulse, a periodic strobe, a square wave, or a single strobe started by software or by hardware.

Top module: `pit_channel`

## Requirements
- R1: Control word bits are: bit 0 selects BCD, bits 3:1 the mode, bits 5:4 the access code, bits 7:6 the channel number. A control word whose channel number differs from parameter CH_IDX is ignored entirely.
- R2: A programming control word (access code not 00) stops the channel and clears any latch and any pending trigger. It sets OUT low for mode 0 and high for every other mode. Nothing counts until a new count is written.
- R3: Access code 01 moves only the low byte and writes zero into the high byte. Code 10 moves only the high byte and writes zero into the low byte. Code 11 moves the low byte and then the high byte, and one toggle is shared by reads and writes.
- R4: In modes 0, 2, 3 and 4, a completed count write is copied into the counter on the next tick (the load tick), with no decrement on that tick. In mode 0 the write also drives OUT low.
- R5: In binary the count decrements modulo 65536. In BCD it decrements across four decimal digits with borrow, so 0x0100 becomes 0x0099 and 0x0000 becomes 0x9999. A loaded 0 therefore acts as 65536 or 10000.
- R6: In modes 0, 2, 3 and 4, GATE low suspends counting. In modes 1 and 5, GATE level has no effect on a running count.
- R7: In mode 0, OUT goes high on the N-th counting tick after the load tick and stays high.
- R8: In mode 1, a GATE rising edge after a count is written makes the next tick reload the counter and drive OUT low. OUT returns high N ticks later. A new rising edge restarts the pulse.
- R9: In mode 2, OUT is low for exactly one tick at the end of every N-tick period. A GATE rising edge while running reloads the counter on the next tick.
- R10: In mode 3, OUT is high for ceil(N/2) counting ticks and then low for floor(N/2) counting ticks, repeating.
- R11: In mode 4, OUT goes low for one tick on the N-th counting tick after the load tick, once only.
- R12: In mode 5, a GATE rising edge after a count is written loads the counter on the next tick. OUT goes low for one tick N ticks later.
- R13: Access code 00 copies the current count into a latch that reads return until they complete the access sequence. A further latch command before then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Bus write strobe, one system cycle per byte |
| rd_i | input | 1 | Bus read strobe, one system cycle per byte |
| addr_i | input | 1 | 1 selects the control word, 0 the count register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current access position |
| cnt_clk_i | input | 1 | Counting clock pin |
| gate_i | input | 1 | Gate pin |
| out_o | output | 1 | Counter output pin |

## Verification
A scoreboard compares OUT after every counting tick with a tick-level model. The run covers each of the six modes with small counts, and uses both odd and even counts in mode 3 so that an off-by-one in either half shows up. Gate low is applied in the gated modes and in the trigger modes, which shows whether the level suspends counting or is ignored. Gate edges are applied while the channel is idle and while it is running, which separates the trigger and reload paths. Readback of borrows across digit boundaries and of zero counts tells BCD from binary arithmetic. Reads of the latch around a repeated latch command, a control word addressed to another channel, and reprogramming while the counter runs check that each of these is either ignored or takes effect.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int DIGITS = CNT_W / 4;

  localparam logic [2:0] M_TC     = 3'd0;
  localparam logic [2:0] M_ONESHT = 3'd1;
  localparam logic [2:0] M_RATE   = 3'd2;
  localparam logic [2:0] M_SQUARE = 3'd3;
  localparam logic [2:0] M_SWSTB  = 3'd4;
  localparam logic [2:0] M_HWSTB  = 3'd5;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } pit_acc_e;

  typedef struct packed {
    logic [1:0] sel;
    pit_acc_e   acc;
    logic [2:0] mode;
    logic       bcd;
  } pit_ctrl_t;

  // codes 6 and 7 alias the two periodic modes
  function automatic logic [2:0] norm_mode(input logic [2:0] m);
    return (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic borrow;
    r = v;
    if (!bcd) begin
      r = v - 1'b1;
    end else begin
      borrow = 1'b1;
      for (int i = 0; i < DIGITS; i++) begin
        if (borrow) begin
          if (v[4*i +: 4] == 4'd0) begin
            r[4*i +: 4] = 4'd9;
          end else begin
            r[4*i +: 4] = v[4*i +: 4] - 4'd1;
            borrow = 1'b0;
          end
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pit_edge_sync.sv
module pit_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= level_o;
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~last_q;

  AST_RISE_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R4
endmodule

// File: rtl/pit_bus_if.sv
module pit_bus_if
  import pit_pkg::*;
#(
  parameter int CH_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [2:0]        mode_o,
  output logic              bcd_o,
  output logic [CNT_W-1:0]  cr_o,
  output logic              prog_o,
  output logic [2:0]        new_mode_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] rdata_o
);
  pit_ctrl_t        cw;
  pit_acc_e         acc_q;
  logic [2:0]       mode_q;
  logic             bcd_q;
  logic [CNT_W-1:0] cr_q;
  logic             hi_q;
  logic             latched_q;
  logic [CNT_W-1:0] latch_val_q;
  logic             ctrl_hit, latch_cmd, prog_cmd, data_wr, data_rd;
  logic [CNT_W-1:0] rd_src;

  assign cw        = pit_ctrl_t'(wdata_i);
  assign ctrl_hit  = wr_i & addr_i & (cw.sel == 2'(CH_IDX));
  assign latch_cmd = ctrl_hit & (cw.acc == ACC_LATCH);
  assign prog_cmd  = ctrl_hit & (cw.acc != ACC_LATCH);
  assign data_wr   = wr_i & ~addr_i;
  assign data_rd   = rd_i & ~addr_i & ~wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= ACC_WORD;
      mode_q      <= M_TC;
      bcd_q       <= 1'b0;
      cr_q        <= '0;
      hi_q        <= 1'b0;
      latched_q   <= 1'b0;
      latch_val_q <= '0;
    end else if (prog_cmd) begin
      acc_q     <= cw.acc;
      mode_q    <= cw.mode;
      bcd_q     <= cw.bcd;
      hi_q      <= 1'b0;
      latched_q <= 1'b0;
    end else begin
      if (latch_cmd && !latched_q) begin
        latched_q   <= 1'b1;
        latch_val_q <= count_i;
      end
      if (data_wr) begin
        unique case (acc_q)
          ACC_LO: cr_q <= {{(CNT_W-BYTE_W){1'b0}}, wdata_i};
          ACC_HI: cr_q <= {wdata_i, {BYTE_W{1'b0}}};
          default: begin
            if (hi_q) cr_q[CNT_W-1:BYTE_W] <= wdata_i;
            else      cr_q[BYTE_W-1:0]     <= wdata_i;
            hi_q <= ~hi_q;
          end
        endcase
      end else if (data_rd) begin
        if (acc_q == ACC_WORD) begin
          hi_q <= ~hi_q;
          if (hi_q) latched_q <= 1'b0;
        end else begin
          latched_q <= 1'b0;
        end
      end
    end
  end

  assign rd_src  = latched_q ? latch_val_q : count_i;
  assign rdata_o = ((acc_q == ACC_HI) || (acc_q == ACC_WORD && hi_q)) ?
                   rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];

  assign mode_o     = mode_q;
  assign bcd_o      = bcd_q;
  assign cr_o       = cr_q;
  assign prog_o     = prog_cmd;
  assign new_mode_o = cw.mode;
  assign load_o     = data_wr & ((acc_q != ACC_WORD) | hi_q);

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_q && !data_rd && !prog_cmd) |=> (latched_q && $stable(latch_val_q))); // R13
  AST_WORD_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && acc_q == ACC_WORD && !hi_q) |=> hi_q); // R3
  AST_TOGGLE_WORD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_q |-> (acc_q == ACC_WORD)); // R3
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
  import pit_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_lvl_i,
  input  logic             gate_rise_i,
  input  logic [2:0]       mode_i,
  input  logic             bcd_i,
  input  logic [CNT_W-1:0] cr_i,
  input  logic             prog_i,
  input  logic [2:0]       new_mode_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  logic [CNT_W-1:0] count_q, c_n, dec1, dec2, cr_low;
  logic             out_q, run_q, lp_q, tp_q, armed_q;
  logic             o_n, r_n, lp_n, tp_n;
  logic [2:0]       eff_mode;
  logic             is_hw, is_periodic;

  assign eff_mode    = norm_mode(mode_i);
  assign is_hw       = (eff_mode == M_ONESHT) || (eff_mode == M_HWSTB);
  assign is_periodic = (eff_mode == M_RATE) || (eff_mode == M_SQUARE);
  assign dec1        = cnt_dec(count_q, bcd_i);
  assign dec2        = cnt_dec(dec1, bcd_i);
  // low half of an odd square-wave period is one tick shorter
  assign cr_low      = cr_i[0] ? cnt_dec(cr_i, bcd_i) : cr_i;

  always_comb begin
    c_n  = count_q;
    o_n  = out_q;
    r_n  = run_q;
    lp_n = lp_q;
    tp_n = tp_q;
    unique case (eff_mode)
      M_TC: begin
        if (lp_q) begin
          c_n = cr_i; lp_n = 1'b0; r_n = 1'b1;
        end else if (run_q && gate_lvl_i) begin
          c_n = dec1;
          if (dec1 == '0) o_n = 1'b1;
        end
      end
      M_ONESHT: begin
        if (tp_q) begin
          c_n = cr_i; o_n = 1'b0; r_n = 1'b1; tp_n = 1'b0;
        end else if (run_q) begin
          c_n = dec1;
          if (dec1 == '0) begin o_n = 1'b1; r_n = 1'b0; end
        end
      end
      M_RATE: begin
        if (lp_q || (tp_q && run_q)) begin
          c_n = cr_i; o_n = 1'b1; r_n = 1'b1; lp_n = 1'b0; tp_n = 1'b0;
        end else if (run_q && gate_lvl_i) begin
          if (dec1 == '0) begin
            c_n = cr_i; o_n = 1'b1;
          end else begin
            c_n = dec1; o_n = (dec1 != CNT_W'(1));
          end
        end
      end
      M_SQUARE: begin
        if (lp_q || (tp_q && run_q)) begin
          c_n = cr_i; o_n = 1'b1; r_n = 1'b1; lp_n = 1'b0; tp_n = 1'b0;
        end else if (run_q && gate_lvl_i) begin
          if (count_q == CNT_W'(1) || count_q == CNT_W'(2)) begin
            o_n = ~out_q;
            c_n = out_q ? cr_low : cr_i;
          end else begin
            c_n = dec2;
          end
        end
      end
      M_SWSTB: begin
        if (lp_q) begin
          c_n = cr_i; o_n = 1'b1; r_n = 1'b1; lp_n = 1'b0;
        end else begin
          if (!out_q) o_n = 1'b1;
          if (run_q && gate_lvl_i) begin
            c_n = dec1;
            if (dec1 == '0) begin o_n = 1'b0; r_n = 1'b0; end
          end
        end
      end
      default: begin
        if (tp_q) begin
          c_n = cr_i; o_n = 1'b1; r_n = 1'b1; tp_n = 1'b0;
        end else begin
          if (!out_q) o_n = 1'b1;
          if (run_q) begin
            c_n = dec1;
            if (dec1 == '0) begin o_n = 1'b0; r_n = 1'b0; end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      out_q   <= 1'b0;
      run_q   <= 1'b0;
      lp_q    <= 1'b0;
      tp_q    <= 1'b0;
      armed_q <= 1'b0;
    end else if (prog_i) begin
      run_q   <= 1'b0;
      lp_q    <= 1'b0;
      tp_q    <= 1'b0;
      armed_q <= 1'b0;
      out_q   <= (norm_mode(new_mode_i) != M_TC);
    end else begin
      if (tick_i) begin
        count_q <= c_n;
        out_q   <= o_n;
        run_q   <= r_n;
        lp_q    <= lp_n;
        tp_q    <= tp_n;
      end
      if (load_i) begin
        if (is_hw) armed_q <= 1'b1;
        else       lp_q    <= 1'b1;
        if (eff_mode == M_TC) out_q <= 1'b0;
      end
      if (gate_rise_i && ((is_hw && armed_q) || (is_periodic && run_q))) tp_q <= 1'b1;
    end
  end

  assign count_o = count_q;
  assign out_o   = out_q;

  AST_PROG_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> (out_q == (eff_mode != M_TC))); // R2
  AST_TC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_mode == M_TC && out_q && !prog_i && !load_i) |=> out_q); // R7
  AST_STROBE_ONE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((eff_mode == M_SWSTB || eff_mode == M_HWSTB) && !out_q && tick_i && !prog_i) |=> out_q); // R11
  AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !gate_lvl_i && !is_hw && !lp_q && !tp_q && !prog_i) |=> $stable(count_q)); // R6
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CH_IDX      = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              cnt_clk_i,
  input  logic              gate_i,
  output logic              out_o
);
  logic             tick, clk_lvl, gate_lvl, gate_rise;
  logic [2:0]       mode, new_mode;
  logic             bcd, prog, load;
  logic [CNT_W-1:0] cr, count;

  pit_edge_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cnt_clk_i), .level_o(clk_lvl), .rise_o(tick)
  );

  pit_edge_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gate_i), .level_o(gate_lvl), .rise_o(gate_rise)
  );

  pit_bus_if #(.CH_IDX(CH_IDX)) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .count_i(count), .mode_o(mode), .bcd_o(bcd), .cr_o(cr),
    .prog_o(prog), .new_mode_o(new_mode), .load_o(load), .rdata_o(rdata_o)
  );

  pit_count_core u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .gate_lvl_i(gate_lvl),
    .gate_rise_i(gate_rise), .mode_i(mode), .bcd_i(bcd), .cr_i(cr), .prog_i(prog),
    .new_mode_i(new_mode), .load_i(load), .count_o(count), .out_o(out_o)
  );

  AST_TICK_NEEDS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> clk_lvl); // R4
endmodule

// File: tb/pit_channel_tb_top.sv
module pit_channel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int SETTLE     = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       cnt_clk = 1'b0, gate = 1'b0;
  logic       out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  bit         isrd_q[$];
  string      tag_q[$];
  event       chk_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_channel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cnt_clk_i(cnt_clk), .gate_i(gate), .out_o(out)
  );

  // ---------------- reference model ----------------
  logic [2:0]  m_mode;
  bit          m_bcd;
  logic [1:0]  m_acc;
  logic [15:0] m_cr, m_cnt, m_latv;
  bit          m_out, m_run, m_lp, m_tp, m_armed, m_hi, m_lat, m_gate;
  int          m_ph;

  function automatic int to_int(logic [15:0] v, bit bcd);
    if (!bcd) return int'(v);
    return int'(v[15:12])*1000 + int'(v[11:8])*100 + int'(v[7:4])*10 + int'(v[3:0]);
  endfunction

  function automatic logic [15:0] from_int(int n, bit bcd);
    if (!bcd) return 16'(n);
    return {4'(n/1000), 4'((n/100)%10), 4'((n/10)%10), 4'(n%10)};
  endfunction

  function automatic logic [15:0] m_dec(logic [15:0] v, bit bcd);
    int n = to_int(v, bcd);
    n = (n == 0) ? (bcd ? 9999 : 65535) : n - 1;
    return from_int(n, bcd);
  endfunction

  function automatic int span(logic [15:0] v, bit bcd);
    int n = to_int(v, bcd);
    if (n == 0) n = bcd ? 10000 : 65536;
    return n;
  endfunction

  function automatic bit m_hw();
    return (m_mode == 3'd1) || (m_mode == 3'd5);
  endfunction

  function automatic void m_reset();
    m_mode = 3'd0; m_bcd = 0; m_acc = 2'd3; m_cr = '0; m_cnt = '0; m_latv = '0;
    m_out = 0; m_run = 0; m_lp = 0; m_tp = 0; m_armed = 0; m_hi = 0; m_lat = 0;
    m_gate = 0; m_ph = 0;
  endfunction

  function automatic void m_ctrl(logic [7:0] b);
    logic [2:0] md;
    if (b[7:6] != 2'd0) return;
    if (b[5:4] == 2'd0) begin
      if (!m_lat) begin m_lat = 1; m_latv = m_cnt; end
      return;
    end
    md = b[3:1];
    if (md == 3'd6) md = 3'd2;
    if (md == 3'd7) md = 3'd3;
    m_mode = md; m_bcd = b[0]; m_acc = b[5:4];
    m_hi = 0; m_lat = 0; m_run = 0; m_lp = 0; m_tp = 0; m_armed = 0;
    m_out = (md != 3'd0);
  endfunction

  function automatic void m_data(logic [7:0] b);
    bit fin = 1;
    case (m_acc)
      2'd1: m_cr = {8'h00, b};
      2'd2: m_cr = {b, 8'h00};
      default: begin
        if (!m_hi) begin m_cr[7:0] = b; fin = 0; end
        else m_cr[15:8] = b;
        m_hi = !m_hi;
      end
    endcase
    if (fin) begin
      if (m_hw()) m_armed = 1; else m_lp = 1;
      if (m_mode == 3'd0) m_out = 0;
    end
  endfunction

  function automatic logic [7:0] m_read();
    logic [15:0] src = m_lat ? m_latv : m_cnt;
    bit hib = (m_acc == 2'd2) || (m_acc == 2'd3 && m_hi);
    if (m_acc == 2'd3) begin
      if (m_hi) m_lat = 0;
      m_hi = !m_hi;
    end else m_lat = 0;
    return hib ? src[15:8] : src[7:0];
  endfunction

  function automatic void m_set_gate(bit v);
    if (v && !m_gate) begin
      if (m_hw() && m_armed) m_tp = 1;
      if ((m_mode == 3'd2 || m_mode == 3'd3) && m_run) m_tp = 1;
    end
    m_gate = v;
  endfunction

  function automatic void m_tick();
    case (m_mode)
      3'd0: begin
        if (m_lp) begin m_cnt = m_cr; m_lp = 0; m_run = 1; end
        else if (m_run && m_gate) begin
          m_cnt = m_dec(m_cnt, m_bcd);
          if (m_cnt == 0) m_out = 1;
        end
      end
      3'd1: begin
        if (m_tp) begin m_cnt = m_cr; m_out = 0; m_run = 1; m_tp = 0; end
        else if (m_run) begin
          m_cnt = m_dec(m_cnt, m_bcd);
          if (m_cnt == 0) begin m_out = 1; m_run = 0; end
        end
      end
      3'd2: begin
        if (m_lp || (m_tp && m_run)) begin
          m_cnt = m_cr; m_out = 1; m_run = 1; m_lp = 0; m_tp = 0;
        end else if (m_run && m_gate) begin
          m_cnt = m_dec(m_cnt, m_bcd);
          if (m_cnt == 0) begin m_cnt = m_cr; m_out = 1; end
          else m_out = (m_cnt != 1);
        end
      end
      3'd3: begin
        if (m_lp || (m_tp && m_run)) begin
          m_out = 1; m_run = 1; m_lp = 0; m_tp = 0;
          m_ph = (span(m_cr, m_bcd) + 1) / 2;
        end else if (m_run && m_gate) begin
          m_ph--;
          if (m_ph == 0) begin
            m_out = !m_out;
            m_ph = m_out ? (span(m_cr, m_bcd) + 1) / 2 : span(m_cr, m_bcd) / 2;
          end
        end
      end
      3'd4: begin
        if (m_lp) begin m_cnt = m_cr; m_out = 1; m_run = 1; m_lp = 0; end
        else begin
          if (!m_out) m_out = 1;
          if (m_run && m_gate) begin
            m_cnt = m_dec(m_cnt, m_bcd);
            if (m_cnt == 0) begin m_out = 0; m_run = 0; end
          end
        end
      end
      default: begin
        if (m_tp) begin m_cnt = m_cr; m_out = 1; m_run = 1; m_tp = 0; end
        else begin
          if (!m_out) m_out = 1;
          if (m_run) begin
            m_cnt = m_dec(m_cnt, m_bcd);
            if (m_cnt == 0) begin m_out = 0; m_run = 0; end
          end
        end
      end
    endcase
  endfunction

  // ---------------- scoreboard monitor ----------------
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        logic [7:0] e, a;
        bit         r;
        string      t;
        e = exp_q.pop_front();
        r = isrd_q.pop_front();
        t = tag_q.pop_front();
        a = r ? rdata : {7'd0, out};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: actual=%0h expected=%0h", t, a, e);
        end
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic push(logic [7:0] e, bit r, string t);
    exp_q.push_back(e);
    isrd_q.push_back(r);
    tag_q.push_back(t);
    -> chk_ev;
    #1;
  endtask

  task automatic chk_out(string t);
    #1;
    push({7'd0, m_out}, 1'b0, t);
  endtask

  task automatic bus_wr(bit a, logic [7:0] b);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = b;
    @(negedge clk);
    wr = 1'b0;
    if (a) m_ctrl(b); else m_data(b);
    repeat (2) @(negedge clk);
  endtask

  task automatic ctrl(logic [1:0] acc, logic [2:0] md, bit bcd);
    bus_wr(1'b1, {2'b00, acc, md, bcd});
  endtask

  task automatic load_word(logic [15:0] v);
    bus_wr(1'b0, v[7:0]);
    bus_wr(1'b0, v[15:8]);
  endtask

  task automatic rd_chk(string t);
    @(negedge clk);
    rd = 1'b1; addr = 1'b0;
    #1;
    push(m_read(), 1'b1, t);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse(string t);
    @(negedge clk);
    cnt_clk = 1'b1;
    repeat (SETTLE) @(negedge clk);
    cnt_clk = 1'b0;
    m_tick();
    repeat (SETTLE) @(negedge clk);
    chk_out(t);
  endtask

  task automatic pulses(int n, string t);
    for (int i = 0; i < n; i++) pulse(t);
  endtask

  task automatic set_gate(bit v);
    @(negedge clk);
    gate = v;
    repeat (SETTLE) @(negedge clk);
    m_set_gate(v);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    chk_out("R2 reset OUT low");
    rd_chk("R3 reset read low byte");
    rd_chk("R3 reset read high byte");

    // mode 0 binary, gate suspension
    set_gate(1'b1);
    ctrl(2'd3, 3'd0, 1'b0);
    chk_out("R2 mode0 init low");
    load_word(16'd5);
    pulses(3, "R7 mode0 counting");
    set_gate(1'b0);
    pulses(3, "R6 mode0 gate low holds");
    set_gate(1'b1);
    pulses(4, "R7 mode0 terminal");

    // single-byte access codes
    ctrl(2'd2, 3'd0, 1'b0);
    bus_wr(1'b0, 8'h01);
    chk_out("R4 mode0 write drives low");
    pulse("R4 load tick");
    rd_chk("R3 high-only load");
    pulse("R5 binary borrow");
    rd_chk("R3 high-only low byte zero");
    ctrl(2'd1, 3'd0, 1'b0);
    bus_wr(1'b0, 8'h03);
    pulses(4, "R3 low-only count");
    rd_chk("R3 low-only readback");

    // BCD and zero counts
    ctrl(2'd3, 3'd0, 1'b1);
    load_word(16'h0100);
    pulses(2, "R5 bcd mode0");
    rd_chk("R5 bcd borrow low");
    rd_chk("R5 bcd borrow high");
    load_word(16'h0000);
    pulses(2, "R5 bcd zero");
    rd_chk("R5 bcd zero low");
    rd_chk("R5 bcd zero high");
    ctrl(2'd3, 3'd0, 1'b0);
    load_word(16'h0000);
    pulses(2, "R5 bin zero");
    rd_chk("R5 bin zero low");
    rd_chk("R5 bin zero high");

    // control word for another channel is ignored
    bus_wr(1'b1, 8'h74);
    chk_out("R1 foreign ctrl out");
    pulses(2, "R1 foreign ctrl counting");
    rd_chk("R1 foreign ctrl low");
    rd_chk("R1 foreign ctrl high");

    // mode 1 one-shot
    ctrl(2'd3, 3'd1, 1'b0);
    chk_out("R2 mode1 init high");
    load_word(16'd3);
    pulses(2, "R8 no trigger yet");
    set_gate(1'b0);
    set_gate(1'b1);
    pulse("R8 trigger load");
    set_gate(1'b0);
    pulses(4, "R6 R8 gate ignored");
    set_gate(1'b1);
    pulses(2, "R8 retrigger");
    set_gate(1'b0);
    set_gate(1'b1);
    pulses(4, "R8 retrigger restart");

    // mode 2 rate generator and latch
    ctrl(2'd3, 3'd2, 1'b0);
    load_word(16'd4);
    pulses(10, "R9 rate");
    set_gate(1'b0);
    pulses(2, "R6 rate gate low");
    set_gate(1'b1);
    pulses(6, "R9 rate gate reload");
    bus_wr(1'b1, 8'h00);
    pulses(2, "R9 rate");
    bus_wr(1'b1, 8'h00);
    pulse("R9 rate");
    rd_chk("R13 latched low");
    rd_chk("R13 latched high");
    pulse("R9 rate");
    rd_chk("R13 live low after release");
    rd_chk("R13 live high after release");

    // mode 3 square wave, odd/even/bcd
    ctrl(2'd3, 3'd3, 1'b0);
    load_word(16'd5);
    pulses(12, "R10 square odd");
    load_word(16'd4);
    pulses(10, "R10 square even reload");
    set_gate(1'b0);
    pulses(2, "R6 square gate low");
    set_gate(1'b1);
    pulses(5, "R10 square gate reload");
    ctrl(2'd3, 3'd3, 1'b1);
    load_word(16'h0010);
    pulses(22, "R10 square bcd");

    // mode 4 software strobe
    ctrl(2'd3, 3'd4, 1'b0);
    load_word(16'd3);
    pulses(2, "R11 strobe");
    set_gate(1'b0);
    pulses(2, "R6 strobe gate low");
    set_gate(1'b1);
    pulses(5, "R11 strobe");

    // mode 5 hardware strobe
    ctrl(2'd3, 3'd5, 1'b0);
    load_word(16'd2);
    pulses(2, "R12 no trigger");
    set_gate(1'b0);
    set_gate(1'b1);
    pulses(5, "R12 strobe");
    set_gate(1'b0);
    set_gate(1'b1);
    pulses(4, "R12 retrigger");

    // reprogramming while running
    ctrl(2'd3, 3'd2, 1'b0);
    load_word(16'd3);
    pulses(2, "R9 rate before reprogram");
    ctrl(2'd3, 3'd0, 1'b0);
    chk_out("R2 reprogram out low");
    pulses(3, "R2 halted until count");
    load_word(16'd2);
    pulses(4, "R4 R7 new count");

    #20;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule